// File: doc/BRIEF.md
# Programmable Sync-Pattern Hunt Receiver

This block is the byte-aligned front end of a synchronous serial receiver. While it hunts, it slides a window over the strobed bit stream and compares it with a sync word of one to four bytes. The sync word is taken from a 32-bit pattern input. On the first exact match it leaves hunt and packs every later bit into a byte, most significant bit first. Each finished byte is offered on a valid/ready output. The sync word itself is never delivered.

A control word sets the sync length and an optional fixed frame length. When the frame length is enabled, the byte that completes the frame carries an end-of-frame flag, and the receiver falls back to hunt on the same clock edge. Hunt can also be forced by a request pulse, or by leaving the one operating mode in which the receiver works. Forcing hunt throws away any byte that is only partly assembled.

Top module: `sync_hunt_rx`

## Requirements
- R1: With `rx_mode` = 3'b101, the receiver leaves hunt (`hunting` falls) on the bit strobe at which the most recent N·8 strobed bits equal the active sync word. The oldest bit compared is the most significant bit of the highest active pattern byte. The sync bytes never appear on the output.
- R2: `ctl[18:17]` selects the sync length: 00 gives 1 byte, compared against `sync_pat[7:0]`; 01 gives 2 bytes (`[15:0]`); 10 gives 3 bytes (`[23:0]`); 11 gives 4 bytes (`[31:0]`). Pattern bits above the active length have no effect. A tail of the sync word alone does not end the hunt.
- R3: After sync, each group of 8 strobed bits is delivered as one byte on `out_data`, first bit in bit 7. The first group starts with the strobe that follows the last sync bit.
- R4: With `ctl[16]` = 1, the byte numbered `ctl[15:0]`+1 in a frame (so 0 means one byte) is delivered with `out_eof` = 1, and the receiver is back in hunt on the same edge. All other bytes carry `out_eof` = 0.
- R5: With `ctl[16]` = 0, a frame never ends by count. No byte carries `out_eof`, and the receiver stays out of hunt whatever `ctl[15:0]` holds.
- R6: `ctl[31:19]` is ignored.
- R7: While `rx_mode` is not 3'b101, the receiver is held in hunt from the next edge and delivers nothing. Any change of `rx_mode` forces hunt.
- R8: A `hunt_req` pulse puts the receiver in hunt on the next edge. The partly assembled byte is dropped: bytes after the next sync contain no bits from before the request.
- R9: Only bits presented with `bit_en` = 1 are used. `rx_bit` is a don't-care on other cycles.
- R10: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data` and `out_eof` hold. A byte that completes during the stall is discarded, and its frame-end effect on hunt still applies.
- R11: After reset, `out_valid` = 0 and `hunting` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Serial data bit |
| bit_en | input | 1 | Marks a cycle that carries a valid bit |
| rx_mode | input | 3 | Receive mode; 3'b101 selects this receiver |
| sync_pat | input | 32 | Sync word, low-order bytes used |
| ctl | input | 32 | [18:17] sync length code, [16] frame-count enable, [15:0] frame length minus one |
| hunt_req | input | 1 | Forces a return to hunt |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts byte |
| out_eof | output | 1 | Byte closes a counted frame |
| hunting | output | 1 | Receiver is searching for sync |

## Verification
The bench sends sync words that are preceded by their own tail bytes, and frames that follow one another with no gap. A window that ignored the length code, or that matched on too few bytes, would sync early and emit bytes that are not expected. A frame-length count that is off by one would put the end flag on the wrong byte or start the next frame misaligned. A hunt request or mode toggle that leaves a partial byte in place would corrupt the first byte after the next sync. Noisy `rx_bit` on cycles without a strobe, and a stall while a frame-ending byte arrives, catch designs that sample without the strobe or overwrite held output.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
   localparam logic [2:0] MODE_BYTE_SYNC = 3'b101;
   localparam int CTL_TC_EN   = 16;
   localparam int CTL_LEN_LSB = 17;
   localparam int BYTE_W      = 8;

   typedef struct packed {
      logic                eof;
      logic [BYTE_W-1:0]   data;
   } rx_beat_t;
endpackage

// File: rtl/sync_hunt_pattern_match.sv
module sync_hunt_pattern_match #(
   parameter int MAX_BYTES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bit_en,
   input  logic                   rx_bit,
   input  logic [8*MAX_BYTES-1:0] pattern,
   input  logic [1:0]             len_code,
   output logic                   match
);
   localparam int WIN_W = 8 * MAX_BYTES;

   logic [WIN_W-1:0] window_q;
   logic [WIN_W-1:0] window_next;
   logic [WIN_W-1:0] mask;

   assign window_next = {window_q[WIN_W-2:0], rx_bit};

   for (genvar b = 0; b < MAX_BYTES; b++) begin : g_mask
      assign mask[8*b +: 8] = {8{(2'(b) <= len_code)}};
   end

   assign match = bit_en && (((window_next ^ pattern) & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      window_q <= '0;
      else if (bit_en) window_q <= window_next;
   end
endmodule

// File: rtl/sync_hunt_byte_asm.sv
module sync_hunt_byte_asm #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              rx_bit,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-2:0] shreg_q;

   assign byte_done = shift_en && (cnt_q == CNT_W'(BYTE_W - 1));
   assign byte_val  = {shreg_q, rx_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shreg_q <= '0;
      end else if (clr) begin
         cnt_q   <= '0;
      end else if (shift_en) begin
         shreg_q <= {shreg_q[BYTE_W-3:0], rx_bit};
         cnt_q   <= byte_done ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sync_hunt_frame_ctl.sv
module sync_hunt_frame_ctl #(
   parameter int TC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            byte_done,
   input  logic            tc_en,
   input  logic [TC_W-1:0] tc_last,
   output logic            frame_end
);
   logic [TC_W-1:0] count_q;

   assign frame_end = byte_done && tc_en && (count_q == tc_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         count_q <= '0;
      else if (clr)       count_q <= '0;
      else if (byte_done) count_q <= count_q + 1'b1;
   end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
   import sync_hunt_pkg::*;
#(
   parameter int MAX_SYNC_BYTES = 4,
   parameter int TC_W           = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_bit,
   input  logic        bit_en,
   input  logic [2:0]  rx_mode,
   input  logic [31:0] sync_pat,
   input  logic [31:0] ctl,
   input  logic        hunt_req,
   output logic [7:0]  out_data,
   output logic        out_valid,
   input  logic        out_ready,
   output logic        out_eof,
   output logic        hunting
);
   localparam int PAT_W = 8 * MAX_SYNC_BYTES;

   if (MAX_SYNC_BYTES != 4) begin : g_bad_sync
      $error("sync_hunt_rx: the 2-bit length code needs MAX_SYNC_BYTES == 4");
   end
   if (TC_W < 1 || TC_W > 16) begin : g_bad_tc
      $error("sync_hunt_rx: TC_W must lie in 1..16");
   end

   logic [2:0] mode_q;
   logic       force_hunt, acquire, shift_en, match;
   logic       byte_done, frame_end;
   logic [7:0] byte_val;
   rx_beat_t   beat_q;
   logic       unused_ctl;

   assign unused_ctl = ^ctl[31:19] ^ ^ctl[15:TC_W-1] ^ ^sync_pat[31:PAT_W-1];

   assign force_hunt = hunt_req || (rx_mode != MODE_BYTE_SYNC) || (rx_mode != mode_q);
   assign acquire    = hunting && !force_hunt && match;
   assign shift_en   = !hunting && !force_hunt && bit_en;

   sync_hunt_pattern_match #(.MAX_BYTES(MAX_SYNC_BYTES)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .rx_bit   (rx_bit),
      .pattern  (sync_pat[PAT_W-1:0]),
      .len_code (ctl[CTL_LEN_LSB +: 2]),
      .match    (match)
   );

   sync_hunt_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (hunting || force_hunt),
      .shift_en  (shift_en),
      .rx_bit    (rx_bit),
      .byte_done (byte_done),
      .byte_val  (byte_val)
   );

   sync_hunt_frame_ctl #(.TC_W(TC_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (hunting || force_hunt),
      .byte_done (byte_done),
      .tc_en     (ctl[CTL_TC_EN]),
      .tc_last   (ctl[TC_W-1:0]),
      .frame_end (frame_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         hunting <= 1'b1;
      end else begin
         mode_q <= rx_mode;
         if (force_hunt)     hunting <= 1'b1;
         else if (acquire)   hunting <= 1'b0;
         else if (frame_end) hunting <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         beat_q    <= '0;
      end else if (byte_done && (!out_valid || out_ready)) begin
         out_valid <= 1'b1;
         beat_q    <= '{eof: frame_end, data: byte_val};
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assign out_data = beat_q.data;
   assign out_eof  = beat_q.eof;
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bit_en,
   input logic [2:0] rx_mode,
   input logic       hunt_req,
   input logic [7:0] out_data,
   input logic       out_valid,
   input logic       out_ready,
   input logic       out_eof,
   input logic       hunting
);
   p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eof));

   p_mode_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mode != 3'b101 |=> hunting);

   p_req_hunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_req |=> hunting);

   p_eof_back_to_hunt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) && out_eof |-> hunting);

   p_strobe_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(bit_en));

   p_sync_in_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hunting) |-> $past(bit_en) && $past(rx_mode) == 3'b101 && !$past(hunt_req));
endmodule

bind sync_hunt_rx sync_hunt_rx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .rx_mode   (rx_mode),
   .hunt_req  (hunt_req),
   .out_data  (out_data),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_eof   (out_eof),
   .hunting   (hunting)
);

// File: tb/sync_hunt_rx_bench.sv
module sync_hunt_rx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_bit = 1'b0;
   logic        bit_en = 1'b0;
   logic [2:0]  rx_mode = 3'b101;
   logic [31:0] sync_pat = '0;
   logic [31:0] ctl = '0;
   logic        hunt_req = 1'b0;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;
   logic        out_valid, out_eof, hunting;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [8:0] exp_q[$];

   always #2.5 clk = ~clk;

   sync_hunt_rx u_sync_hunt_rx (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_en(bit_en),
      .rx_mode(rx_mode), .sync_pat(sync_pat), .ctl(ctl), .hunt_req(hunt_req),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_eof(out_eof), .hunting(hunting)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every handshake (R3, R4, R5)
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3: unexpected byte actual %h expected none", {out_eof, out_data});
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            if ({out_eof, out_data} !== e) begin
               errors++;
               $display("FAIL R3/R4: byte actual %h expected %h", {out_eof, out_data}, e);
            end
         end
      end
   end

   // Each bit is followed by one unstrobed cycle with the inverted bit (R9)
   task automatic send_bit(input logic b);
      rx_bit = b; bit_en = 1'b1;
      @(posedge clk); #1;
      bit_en = 1'b0; rx_bit = ~b;
      @(posedge clk); #1;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic send_sync(input logic [31:0] p, input int nb);
      for (int b = nb - 1; b >= 0; b--) send_byte(p[8*b +: 8]);
   endtask

   task automatic gap(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b0);
   endtask

   task automatic data(input logic [7:0] v, input logic eof);
      exp_q.push_back({eof, v});
      send_byte(v);
   endtask

   task automatic pulse_hunt();
      hunt_req = 1'b1;
      @(posedge clk); #1;
      hunt_req = 1'b0;
   endtask

   task automatic drain(input string req);
      repeat (4) @(posedge clk);
      #1;
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R11: reset state
      chk(out_valid == 1'b0, "R11 valid", out_valid, 0);
      chk(hunting == 1'b1, "R11 hunting", hunting, 1);

      // R1 R4: one-byte sync, three-byte frames back to back
      sync_pat = 32'h0000_00A5;
      ctl = {13'h0, 2'b00, 1'b1, 16'd2};
      gap(16);
      send_sync(sync_pat, 1);
      data(8'h11, 0); data(8'h22, 0); data(8'h33, 1);
      send_sync(sync_pat, 1);
      data(8'h44, 0); data(8'h55, 0); data(8'h66, 1);
      chk(hunting == 1'b1, "R4 hunt after count", hunting, 1);
      drain("R4 frames");

      // R2 R6: two-byte sync, upper pattern bytes and reserved bits set, 1-byte frames
      sync_pat = 32'hABCD_1234;
      ctl = {13'h1FFF, 2'b01, 1'b1, 16'd0};
      gap(40);
      send_sync(sync_pat, 2);
      data(8'h9E, 1);
      send_sync(sync_pat, 2);
      data(8'h0F, 1);
      chk(hunting == 1'b1, "R6 hunt", hunting, 1);
      drain("R2 R6 frames");

      // R2: tail of a three-byte sync alone must not sync
      sync_pat = 32'h77C3_5A96;
      ctl = {13'h0, 2'b10, 1'b1, 16'd1};
      gap(40);
      send_byte(8'h5A); send_byte(8'h96);
      gap(16);
      chk(hunting == 1'b1, "R2 partial sync", hunting, 1);
      send_sync(sync_pat, 3);
      data(8'hE1, 0); data(8'h2D, 1);
      drain("R2 three-byte");

      // R5 R9 R8: four-byte sync, count disabled, noise, partial byte dropped
      sync_pat = 32'hDEAD_BEEF;
      ctl = {13'h0, 2'b11, 1'b0, 16'd0};
      gap(40);
      send_sync(sync_pat, 4);
      data(8'h01, 0); data(8'h80, 0);
      for (int i = 0; i < 20; i++) begin
         rx_bit = i[0]; @(posedge clk); #1;
      end
      data(8'h7E, 0);
      chk(hunting == 1'b0, "R5 no count end", hunting, 0);
      drain("R9 strobe only");
      send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
      pulse_hunt();
      chk(hunting == 1'b1, "R8 hunt_req", hunting, 1);
      gap(40);
      send_sync(sync_pat, 4);
      data(8'h3C, 0);
      pulse_hunt();
      drain("R8 realign");

      // R7: wrong mode holds hunt; mode toggle forces hunt
      rx_mode = 3'b000;
      sync_pat = 32'h0000_00A5;
      ctl = {13'h0, 2'b00, 1'b0, 16'd0};
      gap(16);
      send_sync(sync_pat, 1);
      send_byte(8'h5A);
      chk(hunting == 1'b1, "R7 idle mode", hunting, 1);
      drain("R7 no output");
      rx_mode = 3'b101;
      gap(16);
      send_sync(sync_pat, 1);
      data(8'hC8, 0);
      send_bit(1); send_bit(1); send_bit(0);
      rx_mode = 3'b100;
      @(posedge clk); #1;
      rx_mode = 3'b101;
      @(posedge clk); #1;
      chk(hunting == 1'b1, "R7 mode change", hunting, 1);
      gap(16);
      send_sync(sync_pat, 1);
      data(8'h99, 0);
      pulse_hunt();
      drain("R7 resume");

      // R10: stall; frame-ending byte arrives while held and is dropped
      ctl = {13'h0, 2'b00, 1'b1, 16'd1};
      out_ready = 1'b0;
      gap(16);
      send_sync(sync_pat, 1);
      exp_q.push_back({1'b0, 8'h6B});
      send_byte(8'h6B);
      send_byte(8'hD4);
      chk(out_valid == 1'b1, "R10 valid held", out_valid, 1);
      chk({out_eof, out_data} == 9'h06B, "R10 data held", {out_eof, out_data}, 9'h06B);
      chk(hunting == 1'b1, "R10 frame end applied", hunting, 1);
      out_ready = 1'b1;
      drain("R10 release");
      chk(out_valid == 1'b0, "R10 drained", out_valid, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule